// File: doc/BRIEF.md
# Oversampling Serial Receiver with Character Queue

This block takes an asynchronous, idle-high serial line and turns it into whole characters. The caller supplies a tick at sixteen times the bit rate. The block retimes the line, suppresses short noise, and discards start edges that do not last. It then samples each bit near its centre and assembles the character in the configured bit order. Results go into a small receive queue, which the consumer drains through a valid/ready port.

The frame format is chosen at run time and matches the companion transmitter. A frame has five to nine data bits, sent least or most significant first. An odd or even parity bit may follow the data, and then one or two stop bits. Every queued character carries its own parity-error and frame-error flags. The queue holds two or four characters, selected at run time. A character that completes when the queue is full is dropped, and a sticky overflow flag is raised.

Top module: `serial_rx_queue`

## Requirements
- R1: While reset is held and right after it is released, rd_valid_o and ovf_o are 0.
- R2: cfg_len_i selects the data width: codes 0 to 4 give 5 to 9 bits, and codes 5 to 7 give 9 bits. cfg_msb_first_i=0 means the first data bit is bit 0, and 1 means the first data bit is the top bit of the character. rd_data_o holds the character right-aligned, with unused upper bits at 0.
- R3: With cfg_par_en_i=1, one parity bit follows the data. cfg_par_odd_i=1 expects an odd count of ones over data plus parity, and 0 expects an even count. rd_perr_o is 1 for a character whose count is wrong, and 0 otherwise, including when parity is off.
- R4: A first stop bit sampled low gives rd_ferr_o=1. The receiver then waits for the line to be high before it accepts a new start bit.
- R5: With cfg_two_stop_i=1, the second stop bit is consumed but not checked. A low second stop bit sets no frame error and is not taken as a start bit.
- R6: A low pulse of at most 4 ticks is a false start. It produces no character, and the receiver accepts the next frame normally.
- R7: The line passes a two-flop synchroniser and a 3-tick majority filter. A single-tick pulse, whether during idle or inside a data bit, changes nothing.
- R8: cfg_deep_i=0 gives a 2-entry queue and 1 gives a 4-entry queue. Characters leave in arrival order. An entry is removed at a clock edge where rd_valid_o and rd_ready_i are both 1, and the head entry holds while rd_ready_i is 0. cfg_deep_i may change only while the queue is empty.
- R9: A character that completes while the queue is full is discarded, even if a read happens at that same edge. The queued entries are kept, and ovf_o goes to 1. ovf_o stays at 1 until ovf_clr_i is 1 at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len_i | input | 3 | Data width code |
| cfg_msb_first_i | input | 1 | Bit order: 1 means most significant first |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop_i | input | 1 | Two stop bits |
| cfg_deep_i | input | 1 | Queue depth: 0 gives 2, 1 gives 4 |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| rd_valid_o | output | 1 | Queue head is valid |
| rd_ready_i | input | 1 | Consumer takes the head |
| rd_data_o | output | 9 | Head character, right-aligned |
| rd_perr_o | output | 1 | Parity error of the head character |
| rd_ferr_o | output | 1 | Frame error of the head character |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A character is pushed one clock after the tick that samples its first stop bit. That tick falls about nine to ten ticks into the stop bit, once the two synchroniser flops and the filter window are counted. rd_valid_o therefore rises well before that stop bit ends. The bench waits until the whole frame has been driven and then samples on the falling clock edge, so every queued result is already settled. False-start and glitch checks look for no character one to two full bit times after the stimulus, which is later than any character could appear. Overflow and clear effects are checked on the falling edge after the frame or clear pulse that causes them.

// File: rtl/serial_rx_queue.sv
`timescale 1ns/1ps
module serial_rx_queue #(
  parameter int OVS   = 16,
  parameter int MAXW  = 9,
  parameter int SLOTS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rxd_i,
  input  logic            tick_i,
  input  logic [2:0]      cfg_len_i,
  input  logic            cfg_msb_first_i,
  input  logic            cfg_par_en_i,
  input  logic            cfg_par_odd_i,
  input  logic            cfg_two_stop_i,
  input  logic            cfg_deep_i,
  input  logic            ovf_clr_i,
  output logic            rd_valid_o,
  input  logic            rd_ready_i,
  output logic [MAXW-1:0] rd_data_o,
  output logic            rd_perr_o,
  output logic            rd_ferr_o,
  output logic            ovf_o
);
  localparam int PW = $clog2(OVS);
  localparam int CW = $clog2(MAXW + 1);
  localparam int AW = $clog2(SLOTS);
  localparam int NW = $clog2(SLOTS + 1);
  localparam int EW = MAXW + 2;
  localparam logic [PW-1:0] MID  = PW'(OVS/2 - 2);
  localparam logic [CW-1:0] MINW = CW'(MAXW - 4);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_WAITHI} st_t;

  st_t             st;
  logic [1:0]      sync_q;
  logic [2:0]      win_q;
  logic            filt, mid, push;
  logic [PW-1:0]   phase;
  logic [CW-1:0]   nbit, nbits, shamt;
  logic [MAXW-1:0] shreg, aligned;
  logic            par_acc, perr_q;

  assign filt    = (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) | (win_q[1] & win_q[2]);
  assign nbits   = (cfg_len_i > 3'd4) ? CW'(MAXW) : CW'(cfg_len_i) + MINW;
  assign shamt   = CW'(MAXW) - nbits;
  assign aligned = cfg_msb_first_i ? shreg : shreg >> shamt;
  assign mid     = tick_i && (phase == MID);
  assign push    = mid && (st == S_STOP1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (tick_i) win_q <= {win_q[1:0], sync_q[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      phase   <= '0;
      nbit    <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      perr_q  <= 1'b0;
    end else if (tick_i) begin
      phase <= (phase == PW'(OVS - 1)) ? '0 : phase + 1'b1;
      unique case (st)
        S_IDLE: if (!filt) begin
          st      <= S_START;
          phase   <= '0;
          nbit    <= '0;
          shreg   <= '0;
          par_acc <= 1'b0;
          perr_q  <= 1'b0;
        end
        S_START: if (mid) st <= filt ? S_IDLE : S_DATA;
        S_DATA: if (mid) begin
          shreg   <= cfg_msb_first_i ? {shreg[MAXW-2:0], filt} : {filt, shreg[MAXW-1:1]};
          par_acc <= par_acc ^ filt;
          nbit    <= nbit + 1'b1;
          if (nbit == nbits - 1'b1) st <= cfg_par_en_i ? S_PAR : S_STOP1;
        end
        S_PAR: if (mid) begin
          perr_q <= par_acc ^ filt ^ cfg_par_odd_i;
          st     <= S_STOP1;
        end
        S_STOP1: if (mid) st <= cfg_two_stop_i ? S_STOP2 : (filt ? S_IDLE : S_WAITHI);
        S_STOP2: if (mid) st <= filt ? S_IDLE : S_WAITHI;
        S_WAITHI: if (filt) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [EW-1:0] mem [SLOTS];
  logic [AW-1:0] wptr, rptr;
  logic [NW-1:0] cnt, cap;
  logic          full, wr, pop;

  assign cap        = cfg_deep_i ? NW'(SLOTS) : NW'(SLOTS / 2);
  assign full       = cnt >= cap;
  assign wr         = push && !full;
  assign rd_valid_o = cnt != '0;
  assign pop        = rd_valid_o && rd_ready_i;
  assign {rd_ferr_o, rd_perr_o, rd_data_o} = mem[rptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [NW-1:0] lim);
    return (NW'(p) + 1'b1 >= lim) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= {!filt, perr_q & cfg_par_en_i, aligned};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (wr)  wptr <= step(wptr, cap);
      if (pop) rptr <= step(rptr, cap);
      cnt <= cnt + NW'(wr) - NW'(pop);
      if (push && full)   ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_queue_chk.sv
`timescale 1ns/1ps
module serial_rx_queue_chk #(
  parameter int MAXW = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_i,
  input logic            rd_valid_o,
  input logic            rd_ready_i,
  input logic [MAXW-1:0] rd_data_o,
  input logic            rd_perr_o,
  input logic            rd_ferr_o,
  input logic            ovf_o,
  input logic            ovf_clr_i
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !rd_valid_o && !ovf_o);

  p_push_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid_o) |-> $past(tick_i));

  p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable({rd_ferr_o, rd_perr_o, rd_data_o}));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);

  p_ovf_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(rd_valid_o));
endmodule

bind serial_rx_queue serial_rx_queue_chk #(.MAXW(MAXW)) u_chk (.*);

// File: tb/serial_rx_queue_bench.sv
`timescale 1ns/1ps
module serial_rx_queue_bench;
  logic       clk = 0, rst_n = 0, rxd = 1, tick = 0;
  logic [2:0] cfg_len = 3'd3;
  logic       msb = 0, pen = 0, podd = 0, two = 0, deep = 1, oclr = 0, rdy = 0;
  logic       valid, perr, ferr, ovf;
  logic [8:0] data;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  serial_rx_queue u_serial_rx_queue (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick_i(tick),
    .cfg_len_i(cfg_len), .cfg_msb_first_i(msb), .cfg_par_en_i(pen),
    .cfg_par_odd_i(podd), .cfg_two_stop_i(two), .cfg_deep_i(deep),
    .ovf_clr_i(oclr), .rd_valid_o(valid), .rd_ready_i(rdy),
    .rd_data_o(data), .rd_perr_o(perr), .rd_ferr_o(ferr), .ovf_o(ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_time(logic v, bit gl = 0);
    for (int i = 0; i < 32; i++) begin
      rxd = (gl && (i == 16 || i == 17)) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic send(logic [8:0] d, int n, bit bad_par = 0, bit bad_stop = 0,
                      bit low_stop2 = 0, int gl_bit = -1);
    logic p;
    p = podd ^ bad_par;
    bit_time(1'b0);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = msb ? d[n-1-i] : d[i];
      p = p ^ b;
      bit_time(b, gl_bit == i);
    end
    if (pen) bit_time(p);
    bit_time(!bad_stop);
    if (two) bit_time(!low_stop2);
    if (bad_stop || low_stop2) bit_time(1'b1);
  endtask

  task automatic take(string req, logic [8:0] d, logic pe, logic fe);
    repeat (3) @(negedge clk);
    chk({req, " valid"}, valid, 1);
    chk({req, " data"}, data, d);
    chk({req, " perr"}, perr, pe);
    chk({req, " ferr"}, ferr, fe);
    rdy = 1;
    @(negedge clk);
    rdy = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 valid in reset", valid, 0);
    chk("R1 ovf in reset", ovf, 0);
    rst_n = 1;
    repeat (40) @(negedge clk);
    chk("R1 valid after reset", valid, 0);
    chk("R1 ovf after reset", ovf, 0);

    for (int len = 0; len < 5; len++)
      for (int m = 0; m < 2; m++)
        for (int pm = 0; pm < 3; pm++)
          for (int t = 0; t < 2; t++)
            for (int k = 0; k < 3; k++) begin
              int n;
              logic [8:0] d;
              bit bp;
              cfg_len = 3'(len); msb = m[0]; pen = (pm != 0); podd = (pm == 2); two = t[0];
              n  = len + 5;
              d  = 9'((k * 173 + len * 29 + m * 7 + 1) & ((1 << n) - 1));
              bp = pen && (k == 2);
              send(d, n, bp);
              take(pen ? "R3 parity sweep" : "R2 format sweep", d, bp, 1'b0);
            end

    cfg_len = 3'd7; msb = 0; pen = 0; two = 0;
    send(9'h1A5, 9);
    take("R2 code 7 gives 9 bits", 9'h1A5, 0, 0);

    cfg_len = 3'd3;
    send(9'h5A, 8, 0, 1);
    take("R4 stop low", 9'h5A, 0, 1);
    send(9'hC3, 8);
    take("R4 recovery", 9'hC3, 0, 0);

    two = 1;
    send(9'h3C, 8, 0, 0, 1);
    take("R5 second stop low", 9'h3C, 0, 0);
    repeat (64) @(negedge clk);
    chk("R5 no extra char", valid, 0);
    two = 0;

    rxd = 0;
    repeat (8) @(negedge clk);
    rxd = 1;
    repeat (64) @(negedge clk);
    chk("R6 false start dropped", valid, 0);
    send(9'h96, 8);
    take("R6 next frame", 9'h96, 0, 0);

    bit_time(1'b1, 1);
    bit_time(1'b1);
    chk("R7 idle glitch", valid, 0);
    send(9'hA5, 8, 0, 0, 0, 1);
    take("R7 glitch in zero bit", 9'hA5, 0, 0);
    send(9'hA5, 8, 0, 0, 0, 2);
    take("R7 glitch in one bit", 9'hA5, 0, 0);

    deep = 0;
    send(9'h11, 8); send(9'h22, 8);
    chk("R8 shallow no ovf", ovf, 0);
    send(9'h33, 8);
    chk("R9 ovf set", ovf, 1);
    take("R9 kept first", 9'h11, 0, 0);
    take("R9 kept second", 9'h22, 0, 0);
    chk("R8 shallow holds two", valid, 0);
    chk("R9 sticky", ovf, 1);
    oclr = 1;
    @(negedge clk);
    oclr = 0;
    chk("R9 cleared", ovf, 0);

    deep = 1;
    for (int i = 0; i < 4; i++) send(9'(8'h41 + i), 8);
    chk("R8 deep holds four", ovf, 0);
    send(9'h45, 8);
    chk("R9 deep ovf", ovf, 1);
    for (int i = 0; i < 4; i++) take("R8 order", 9'(8'h41 + i), 0, 0);
    chk("R8 deep drained", valid, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule